// File: doc/BRIEF.md
# Configurable Test Address Generator

This block produces the stream of addresses that a memory test engine issues. Three generation modes are available. The sequential mode walks upward from a programmed start address by a programmed stride. The random mode gives a fresh pseudo-random address on every request. The random-then-sequential mode takes one random address and then walks a programmed number of strides from it before it draws the next random value. Every address lives in a 25-bit space: arithmetic past 0x1FF_FFFF wraps back to zero.

Addresses are handed out one at a time on a valid/ready handshake. Three control pulses steer the generator between test blocks. An initialise pulse loads the seed or the start address and enables output. A block-done pulse marks the end of a block. In sequential mode with return-to-start set, it also reloads the start address. A replay pulse restores the generator state saved at the start of the current block, so that the read phase walks exactly the addresses the write phase walked. An optional fixed mask forces chosen address bits to a programmed value, which keeps the traffic inside one row or one bank.

Top module: `tgen_addr_gen`

## Requirements
- R1: After reset, `addr_valid` stays 0 until the first `gen_init` pulse.
- R2: The cycle after a `gen_init` pulse in sequential mode (`cfg_mode` = 0, or the spare code 3), the generator address equals `cfg_start`, and `addr_valid` is 1 if no control pulse is present.
- R3: In sequential mode, each accepted handshake (`addr_valid` and `addr_ready` both 1 at a clock edge) makes the next address the previous address plus `cfg_step`, taken modulo 2^25, so 0x1FF_FFFF + 1 gives 0.
- R4: While `addr_ready` is 0, the generator state and `addr_out` hold their values, given that the mask inputs are unchanged.
- R5: In random mode (`cfg_mode` = 1), `gen_init` loads the 32-bit LFSR with `cfg_seed`, or with 1 when the seed is 0. The address is the LFSR's low 25 bits. Each accepted handshake steps the LFSR once: shift right by one and, if the bit shifted out was 1, XOR with 0x80200003.
- R6: In random-sequential mode (`cfg_mode` = 2), a random address is followed by exactly `cfg_run_len` addresses, each `cfg_step` above the one before. The next handshake then steps the LFSR and takes a new random address, as in R5. With `cfg_run_len` = 0 the mode behaves like random mode.
- R7: On `blk_done` in sequential mode with `cfg_return_start` = 1, the address reloads `cfg_start`. In every other case, `blk_done` leaves the address unchanged.
- R8: `gen_replay` restores the address, the LFSR and the run count that held just after the most recent `gen_init` or `blk_done`.
- R9: With `cfg_mask_en` = 1, every bit of `addr_out` whose `cfg_mask_bits` bit is 1 equals the matching `cfg_mask_val` bit, and the other bits come from the generator. With `cfg_mask_en` = 0, `addr_out` is the generator address. Masking never alters the generator sequence.
- R10: In any cycle in which `gen_init`, `gen_replay` or `blk_done` is 1, `addr_valid` is 0 and no handshake takes place. When several of these pulses coincide, the priority is `gen_init`, then `gen_replay`, then `blk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 sequential, 1 random, 2 random-sequential, 3 sequential |
| cfg_start | input | 25 | Start address for sequential mode |
| cfg_step | input | 25 | Stride between sequential addresses |
| cfg_run_len | input | 12 | Sequential addresses after each random one |
| cfg_return_start | input | 1 | Reload start address on block done (sequential mode) |
| cfg_seed | input | 32 | LFSR seed loaded on init |
| cfg_mask_en | input | 1 | Enable fixed address masking |
| cfg_mask_bits | input | 25 | 1 marks an address bit that is forced |
| cfg_mask_val | input | 25 | Values for forced bits |
| gen_init | input | 1 | Load the generator and enable output |
| gen_replay | input | 1 | Restore the state saved at block start |
| blk_done | input | 1 | End of block; saves the new block-start state |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | 25 | Current (masked) address |

## Verification
The hardest situation to reach is a replay whose saved state lies several blocks back and in the middle of a random-sequential run. That saved state is set by whichever of `gen_init` or `blk_done` came last, and not by the replay itself. The stimulus first runs directed blocks that cross the 0x1FF_FFFF wrap, the return-to-start reload and a replay. It then runs a long stretch with random ready, random block-done and replay pulses, and mode switches in between. A behavioural model follows the saved state and is compared with the ports on every clock.

// File: rtl/tgen_addr_pkg.sv
package tgen_addr_pkg;
   typedef enum logic [1:0] {
      MODE_SEQ  = 2'd0,
      MODE_RAND = 2'd1,
      MODE_RSEQ = 2'd2,
      MODE_SPR  = 2'd3
   } tgen_mode_e;

   // Sequential behaviour covers the spare encoding as well.
   function automatic logic mode_is_seq(input logic [1:0] m);
      return (m == MODE_SEQ) || (m == MODE_SPR);
   endfunction

   function automatic logic mode_is_rnd(input logic [1:0] m);
      return (m == MODE_RAND) || (m == MODE_RSEQ);
   endfunction
endpackage

// File: rtl/tgen_lfsr_step.sv
module tgen_lfsr_step #(
   parameter int unsigned          LFSR_W = 32,
   parameter logic [LFSR_W-1:0]    POLY   = 32'h8020_0003
) (
   input  logic [LFSR_W-1:0] cur,
   output logic [LFSR_W-1:0] nxt
);
   logic [LFSR_W-1:0] shifted;

   assign shifted = {1'b0, cur[LFSR_W-1:1]};

   // Galois form: the bit shifted out decides whether the taps are applied.
   for (genvar b = 0; b < LFSR_W; b++) begin : g_bit
      if (POLY[b]) begin : g_tap
         assign nxt[b] = shifted[b] ^ cur[0];
      end else begin : g_pass
         assign nxt[b] = shifted[b];
      end
   end
endmodule

// File: rtl/tgen_mask.sv
module tgen_mask #(
   parameter int unsigned ADDR_W = 25
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] bits,
   input  logic [ADDR_W-1:0] val,
   input  logic [ADDR_W-1:0] raw,
   output logic [ADDR_W-1:0] masked
);
   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      assign masked[b] = (en && bits[b]) ? val[b] : raw[b];
   end
endmodule

// File: rtl/tgen_next_state.sv
module tgen_next_state
   import tgen_addr_pkg::*;
#(
   parameter int unsigned       ADDR_W = 25,
   parameter int unsigned       LFSR_W = 32,
   parameter int unsigned       CNT_W  = 12,
   parameter logic [LFSR_W-1:0] POLY   = 32'h8020_0003
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] start,
   input  logic [ADDR_W-1:0] step,
   input  logic [CNT_W-1:0]  run_len,
   input  logic              ret_start,
   input  logic [LFSR_W-1:0] seed,
   input  logic              do_init,
   input  logic              do_replay,
   input  logic              do_done,
   input  logic              do_adv,
   input  logic [ADDR_W-1:0] cur_base,
   input  logic [LFSR_W-1:0] cur_lfsr,
   input  logic [CNT_W-1:0]  cur_cnt,
   input  logic [ADDR_W-1:0] snap_base,
   input  logic [LFSR_W-1:0] snap_lfsr,
   input  logic [CNT_W-1:0]  snap_cnt,
   output logic [ADDR_W-1:0] nxt_base,
   output logic [LFSR_W-1:0] nxt_lfsr,
   output logic [CNT_W-1:0]  nxt_cnt
);
   localparam logic [LFSR_W-1:0] ONE_SEED = LFSR_W'(1);

   logic [LFSR_W-1:0] seed_nz;
   logic [LFSR_W-1:0] lfsr_adv;
   logic [ADDR_W-1:0] stride_sum;
   logic              run_open;

   assign seed_nz    = (seed == '0) ? ONE_SEED : seed;
   assign stride_sum = cur_base + step;
   assign run_open   = (cur_cnt < run_len);

   tgen_lfsr_step #(.LFSR_W(LFSR_W), .POLY(POLY)) u_step (
      .cur (cur_lfsr),
      .nxt (lfsr_adv)
   );

   always_comb begin
      nxt_base = cur_base;
      nxt_lfsr = cur_lfsr;
      nxt_cnt  = cur_cnt;
      if (do_init) begin
         nxt_lfsr = seed_nz;
         nxt_cnt  = '0;
         nxt_base = mode_is_rnd(mode) ? seed_nz[ADDR_W-1:0] : start;
      end else if (do_replay) begin
         nxt_base = snap_base;
         nxt_lfsr = snap_lfsr;
         nxt_cnt  = snap_cnt;
      end else if (do_done) begin
         if (mode_is_seq(mode) && ret_start) begin
            nxt_base = start;
         end
      end else if (do_adv) begin
         unique case (mode)
            MODE_RAND: begin
               nxt_lfsr = lfsr_adv;
               nxt_base = lfsr_adv[ADDR_W-1:0];
            end
            MODE_RSEQ: begin
               if (run_open) begin
                  nxt_base = stride_sum;
                  nxt_cnt  = cur_cnt + CNT_W'(1);
               end else begin
                  nxt_lfsr = lfsr_adv;
                  nxt_base = lfsr_adv[ADDR_W-1:0];
                  nxt_cnt  = '0;
               end
            end
            default: begin
               nxt_base = stride_sum;
            end
         endcase
      end
   end
endmodule

// File: rtl/tgen_addr_gen.sv
module tgen_addr_gen
   import tgen_addr_pkg::*;
#(
   parameter int unsigned       ADDR_W = 25,
   parameter int unsigned       LFSR_W = 32,
   parameter int unsigned       CNT_W  = 12,
   parameter logic [LFSR_W-1:0] POLY   = 32'h8020_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [ADDR_W-1:0] cfg_step,
   input  logic [CNT_W-1:0]  cfg_run_len,
   input  logic              cfg_return_start,
   input  logic [LFSR_W-1:0] cfg_seed,
   input  logic              cfg_mask_en,
   input  logic [ADDR_W-1:0] cfg_mask_bits,
   input  logic [ADDR_W-1:0] cfg_mask_val,
   input  logic              gen_init,
   input  logic              gen_replay,
   input  logic              blk_done,
   output logic              addr_valid,
   input  logic              addr_ready,
   output logic [ADDR_W-1:0] addr_out
);
   if (ADDR_W < 1 || ADDR_W > LFSR_W) begin : g_bad_addr_w
      $error("tgen_addr_gen: ADDR_W must be in 1..LFSR_W");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("tgen_addr_gen: CNT_W must be in 1..16");
   end
   if (!POLY[LFSR_W-1]) begin : g_bad_poly
      $error("tgen_addr_gen: POLY must have its top bit set");
   end

   logic              running_q;
   logic [ADDR_W-1:0] base_q,  base_d;
   logic [LFSR_W-1:0] lfsr_q,  lfsr_d;
   logic [CNT_W-1:0]  cnt_q,   cnt_d;
   logic [ADDR_W-1:0] snap_base;
   logic [LFSR_W-1:0] snap_lfsr;
   logic [CNT_W-1:0]  snap_cnt;
   logic              ctrl_any;
   logic              take;

   assign ctrl_any   = gen_init | gen_replay | blk_done;
   assign addr_valid = running_q & ~ctrl_any;
   assign take       = addr_valid & addr_ready;

   tgen_next_state #(
      .ADDR_W(ADDR_W), .LFSR_W(LFSR_W), .CNT_W(CNT_W), .POLY(POLY)
   ) u_next (
      .mode      (cfg_mode),
      .start     (cfg_start),
      .step      (cfg_step),
      .run_len   (cfg_run_len),
      .ret_start (cfg_return_start),
      .seed      (cfg_seed),
      .do_init   (gen_init),
      .do_replay (gen_replay),
      .do_done   (blk_done),
      .do_adv    (take),
      .cur_base  (base_q),
      .cur_lfsr  (lfsr_q),
      .cur_cnt   (cnt_q),
      .snap_base (snap_base),
      .snap_lfsr (snap_lfsr),
      .snap_cnt  (snap_cnt),
      .nxt_base  (base_d),
      .nxt_lfsr  (lfsr_d),
      .nxt_cnt   (cnt_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         base_q    <= '0;
         lfsr_q    <= LFSR_W'(1);
         cnt_q     <= '0;
      end else begin
         if (gen_init) running_q <= 1'b1;
         base_q <= base_d;
         lfsr_q <= lfsr_d;
         cnt_q  <= cnt_d;
      end
   end

   // Block-start snapshot: taken on init and at every block boundary,
   // except when a replay of higher priority owns the cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_base <= '0;
         snap_lfsr <= LFSR_W'(1);
         snap_cnt  <= '0;
      end else if (gen_init || (blk_done && !gen_replay)) begin
         snap_base <= base_d;
         snap_lfsr <= lfsr_d;
         snap_cnt  <= cnt_d;
      end
   end

   tgen_mask #(.ADDR_W(ADDR_W)) u_mask (
      .en     (cfg_mask_en),
      .bits   (cfg_mask_bits),
      .val    (cfg_mask_val),
      .raw    (base_q),
      .masked (addr_out)
   );
endmodule

// File: rtl/tgen_addr_chk.sv
module tgen_addr_chk
   import tgen_addr_pkg::*;
#(
   parameter int unsigned ADDR_W = 25,
   parameter int unsigned LFSR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_mode,
   input logic [ADDR_W-1:0] cfg_start,
   input logic [ADDR_W-1:0] cfg_step,
   input logic              gen_init,
   input logic              gen_replay,
   input logic              addr_valid,
   input logic              addr_ready,
   input logic [ADDR_W-1:0] base_q,
   input logic [LFSR_W-1:0] lfsr_q,
   input logic [ADDR_W-1:0] snap_base
);
   logic seen_init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_init <= 1'b0;
      else if (gen_init) seen_init <= 1'b1;
   end

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_init |-> !addr_valid);

   p_init_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_init && cfg_mode == MODE_SEQ) |=> base_q == $past(cfg_start));

   p_seq_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_ready && cfg_mode == MODE_SEQ)
      |=> base_q == ADDR_W'($past(base_q) + $past(cfg_step)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !addr_ready) |=> ($stable(base_q) && $stable(lfsr_q)));

   p_rand_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_ready && cfg_mode == MODE_RAND)
      |=> lfsr_q != $past(lfsr_q));

   p_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_replay && !gen_init) |=> base_q == $past(snap_base));
endmodule

bind tgen_addr_gen tgen_addr_chk #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_mode   (cfg_mode),
   .cfg_start  (cfg_start),
   .cfg_step   (cfg_step),
   .gen_init   (gen_init),
   .gen_replay (gen_replay),
   .addr_valid (addr_valid),
   .addr_ready (addr_ready),
   .base_q     (base_q),
   .lfsr_q     (lfsr_q),
   .snap_base  (snap_base)
);

// File: tb/tgen_addr_gen_test.sv
module tgen_addr_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 25;
   localparam int LW = 32;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_mode = 2'd0;
   logic [AW-1:0] cfg_start = '0;
   logic [AW-1:0] cfg_step = '0;
   logic [CW-1:0] cfg_run_len = '0;
   logic          cfg_return_start = 1'b0;
   logic [LW-1:0] cfg_seed = '0;
   logic          cfg_mask_en = 1'b0;
   logic [AW-1:0] cfg_mask_bits = '0;
   logic [AW-1:0] cfg_mask_val = '0;
   logic          gen_init = 1'b0;
   logic          gen_replay = 1'b0;
   logic          blk_done = 1'b0;
   logic          addr_ready = 1'b0;
   logic          addr_valid;
   logic [AW-1:0] addr_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   tgen_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start(cfg_start),
      .cfg_step(cfg_step), .cfg_run_len(cfg_run_len),
      .cfg_return_start(cfg_return_start), .cfg_seed(cfg_seed),
      .cfg_mask_en(cfg_mask_en), .cfg_mask_bits(cfg_mask_bits),
      .cfg_mask_val(cfg_mask_val), .gen_init(gen_init), .gen_replay(gen_replay),
      .blk_done(blk_done), .addr_valid(addr_valid), .addr_ready(addr_ready),
      .addr_out(addr_out)
   );

   // ---------------- behavioural reference ----------------
   bit            m_run;
   logic [AW-1:0] m_base, s_base;
   logic [LW-1:0] m_lfsr, s_lfsr;
   int            m_cnt, s_cnt;

   function automatic logic [LW-1:0] lfsr_next(logic [LW-1:0] s);
      return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
   endfunction

   function automatic bit seq_like(logic [1:0] m);
      return (m == 2'd0) || (m == 2'd3);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_base = '0; m_lfsr = 1; m_cnt = 0;
         s_base = '0; s_lfsr = 1; s_cnt = 0;
      end else if (gen_init) begin
         m_run  = 1;
         m_lfsr = (cfg_seed == 0) ? 32'd1 : cfg_seed;
         m_cnt  = 0;
         m_base = seq_like(cfg_mode) ? cfg_start : m_lfsr[AW-1:0];
         s_base = m_base; s_lfsr = m_lfsr; s_cnt = m_cnt;
      end else if (gen_replay) begin
         m_base = s_base; m_lfsr = s_lfsr; m_cnt = s_cnt;
      end else if (blk_done) begin
         if (seq_like(cfg_mode) && cfg_return_start) m_base = cfg_start;
         s_base = m_base; s_lfsr = m_lfsr; s_cnt = m_cnt;
      end else if (m_run && addr_ready) begin
         if (seq_like(cfg_mode)) begin
            m_base = m_base + cfg_step;
         end else if (cfg_mode == 2'd2 && m_cnt < int'(cfg_run_len)) begin
            m_base = m_base + cfg_step;
            m_cnt++;
         end else begin
            m_lfsr = lfsr_next(m_lfsr);
            m_base = m_lfsr[AW-1:0];
            m_cnt  = 0;
         end
      end
   end

   function automatic logic [AW-1:0] apply_mask(logic [AW-1:0] a);
      return cfg_mask_en ? ((a & ~cfg_mask_bits) | (cfg_mask_val & cfg_mask_bits)) : a;
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, half a period after the edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         automatic bit ev = m_run && !(gen_init || gen_replay || blk_done);
         check(addr_valid === ev, cur_req, "addr_valid", addr_valid, ev);
         check(addr_out === apply_mask(m_base), cur_req, "addr_out", addr_out, apply_mask(m_base));
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   localparam logic [AW-1:0] START = 25'h1FF_FFF0;
   logic [AW-1:0] saved;
   logic [LW-1:0] l1;

   initial begin
      // R1: reset state
      tick(3);
      check(addr_valid == 0, "R1", "valid in reset", addr_valid, 0);
      rst_n = 1;
      tick(2);
      check(addr_valid == 0, "R1", "valid before init", addr_valid, 0);

      // R2: init in sequential mode
      cur_req = "R2";
      cfg_mode = 2'd0; cfg_start = START; cfg_step = 25'd8;
      gen_init = 1; tick(); gen_init = 0;
      #1 check(addr_out == START && addr_valid, "R2", "start addr", addr_out, START);

      // R3: stride and wrap past 0x1FFFFFF
      cur_req = "R3";
      addr_ready = 1; tick();
      check(addr_out == 25'h1FF_FFF8, "R3", "stride", addr_out, 25'h1FF_FFF8);
      tick();
      check(addr_out == 25'h0, "R3", "wrap to zero", addr_out, 0);
      tick();
      check(addr_out == 25'h8, "R3", "after wrap", addr_out, 8);

      // R4: hold while not ready
      cur_req = "R4";
      addr_ready = 0; tick(3);
      check(addr_out == 25'h8, "R4", "hold", addr_out, 8);

      // R7: return to start / no return
      cur_req = "R7";
      cfg_return_start = 1; addr_ready = 1; tick(2);
      blk_done = 1; addr_ready = 0; tick(); blk_done = 0;
      check(addr_out == START, "R7", "reload start", addr_out, START);
      cfg_return_start = 0; addr_ready = 1; tick(2); addr_ready = 0;
      saved = addr_out;
      blk_done = 1; tick(); blk_done = 0;
      check(addr_out == saved, "R7", "no reload", addr_out, saved);

      // R8: replay back to block start
      cur_req = "R8";
      addr_ready = 1; tick(4); addr_ready = 0;
      gen_replay = 1; tick(); gen_replay = 0;
      check(addr_out == saved, "R8", "replay seq", addr_out, saved);

      // R5: random mode
      cur_req = "R5";
      cfg_mode = 2'd1; cfg_seed = 32'h0000_ACE1;
      gen_init = 1; tick(); gen_init = 0;
      check(addr_out == 25'hACE1, "R5", "seed addr", addr_out, 25'hACE1);
      l1 = lfsr_next(32'h0000_ACE1);
      addr_ready = 1; tick(); addr_ready = 0;
      check(addr_out == l1[AW-1:0], "R5", "lfsr step", addr_out, l1[AW-1:0]);
      cfg_seed = 0; gen_init = 1; tick(); gen_init = 0;
      check(addr_out == 25'h1, "R5", "zero seed", addr_out, 1);

      // R6: random-sequential runs
      cur_req = "R6";
      cfg_mode = 2'd2; cfg_run_len = 12'd3; cfg_step = 25'd4;
      cfg_seed = 32'h1234_5678;
      gen_init = 1; tick(); gen_init = 0;
      addr_ready = 1; tick(3); addr_ready = 0;
      check(addr_out == 25'h034_5684, "R6", "run end", addr_out, 25'h034_5684);
      l1 = lfsr_next(32'h1234_5678);
      addr_ready = 1; tick(); addr_ready = 0;
      check(addr_out == l1[AW-1:0], "R6", "new random", addr_out, l1[AW-1:0]);

      // R9: fixed masking
      cur_req = "R9";
      cfg_mode = 2'd0; cfg_start = 25'h0FF_FF00; cfg_step = 25'h40;
      cfg_mask_en = 1; cfg_mask_bits = 25'h1F0_0000; cfg_mask_val = 25'h0A0_0000;
      gen_init = 1; tick(); gen_init = 0;
      addr_ready = 1; tick(6); addr_ready = 0;
      check((addr_out & cfg_mask_bits) == cfg_mask_val, "R9", "forced bits",
            addr_out & cfg_mask_bits, cfg_mask_val);
      cfg_mask_en = 0; #1;
      check(addr_out == 25'h100_0080, "R9", "unmasked sequence", addr_out, 25'h100_0080);

      // R10: priority and valid during control pulses
      cur_req = "R10";
      gen_init = 1; gen_replay = 1; tick();
      check(addr_valid == 0, "R10", "valid during pulse", addr_valid, 0);
      gen_init = 0; gen_replay = 0; #1;
      check(addr_out == 25'h0FF_FF00, "R10", "init wins", addr_out, 25'h0FF_FF00);

      // random stretch across modes
      cur_req = "R8";
      for (int i = 0; i < 600; i++) begin
         addr_ready = $urandom_range(0, 1);
         blk_done   = ($urandom_range(0, 15) == 0);
         gen_replay = ($urandom_range(0, 19) == 0);
         cfg_return_start = $urandom_range(0, 1);
         if (i % 150 == 0) begin
            cfg_mode = 2'($urandom_range(0, 3));
            cfg_seed = $urandom();
            gen_init = 1;
         end else begin
            gen_init = 0;
         end
         tick();
      end
      gen_init = 0; gen_replay = 0; blk_done = 0; addr_ready = 0;
      tick(2);

      finished = 1;
      summary();
      $finish;
   end
endmodule